// File: doc/BRIEF.md
# Interrupt Polling and Vectoring Unit

This unit sits beside a small CPU core and decides when, and to where, the core takes a hardware call into an interrupt service routine. One clock cycle stands for one machine cycle. Fifteen request flags are captured in a register at every clock edge. During the next cycle, that captured set is masked and arbitrated. If no blocking rule applies, the unit raises a single-cycle call strobe with the 16-bit service address.

Arbitration works in two steps. Two priority levels are resolved first. Within a level, a fixed order decides, with source index 0 the strongest and index 14 the weakest. Two in-service bits, one per level, record which routines are running. A return pulse from the core clears the higher of the two bits.

The unit also sends a clear pulse back to any source whose flag is meant to be dropped by hardware when its routine is entered. It keeps nothing about requests it refused. Each poll looks only at the flags captured at the last edge.

Top module: `irq_vector_unit`

## Requirements
- R1: Request flags are captured at each rising edge. A flag first raised in the cycle before an edge can produce a call only in the cycle after that edge, never in the cycle in which it was raised.
- R2: No call is issued while a routine of the same or a higher level is in service. A call made at level L blocks further level-L calls in the following cycles.
- R3: No call is issued while `lastCycle` is 0. The call appears once `lastCycle` is 1 and the captured request is still present.
- R4: No call is issued while `guardInstr` is 1.
- R5: A refused request is not remembered. If a request drops before the blocking condition ends, no call is ever made for it.
- R6: Within one level, the lowest source index wins. The index order is: 0 ext0, 1 serial expansion port, 2 ext2, 3 timer0, 4 capture unit A, 5 ext3, 6 ext1, 7 converter, 8 ext4, 9 timer1, 10 capture unit B, 11 ext5, 12 serial port, 13 timer2, 14 ext6.
- R7: When a high-level request (`srcPrio` bit 1) and a low-level request compete, the high-level request wins regardless of index. A high-level request may also be called while only a low-level routine is in service.
- R8: The vector for each index 0..14 is 0x0003, 0x004B, 0x0053, 0x000B, 0x0033, 0x005B, 0x0013, 0x0043, 0x0063, 0x001B, 0x003B, 0x006B, 0x0023, 0x002B, 0x0073.
- R9: `hwClear` pulses the bit of the selected source in the call cycle for indices 2, 3, 5, 8, 9, 11 and 14, for index 0 when `edgeTrig[0]`=1, and for index 6 when `edgeTrig[1]`=1. It stays 0 for every other case.
- R10: A source takes part in arbitration only when both its `srcEnable` bit and `globalEnable` are 1.
- R11: `callReq` lasts exactly one cycle per call. `vectorAddr` and `hwClear` are 0 whenever `callReq` is 0.
- R12: After reset, no routine is in service and the outputs are 0. A `retiPulse` clears only the higher in-service level, so a remaining low-level routine still blocks low-level requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqFlags | input | 15 | Raw request flags, one per source index |
| srcEnable | input | 15 | Per-source enable bits |
| srcPrio | input | 15 | Per-source level, 1 = high |
| globalEnable | input | 1 | Master enable for all sources |
| edgeTrig | input | 2 | Bit 0: ext0 is edge-triggered; bit 1: ext1 is edge-triggered |
| lastCycle | input | 1 | Current cycle is the final cycle of the instruction |
| guardInstr | input | 1 | Current instruction is a return or a write to enable/priority bits |
| retiPulse | input | 1 | One-cycle pulse marking the end of a service routine |
| callReq | output | 1 | One-cycle hardware call strobe |
| vectorAddr | output | 16 | Service address, valid with callReq |
| hwClear | output | 15 | One-cycle clear pulse for the flag of the selected source |

## Verification
A corrupted in-service bit shows up at the ports on the next poll. Either a same-level request gets a second strobe straight after its call, or a high-level request stays silent after a return pulse. A stale capture register shows up as a strobe in the cycle after a request has been dropped, or as a missing strobe one edge after a flag is raised. The stimulus is placed to expose exactly those cycles. A wrong arbitration or address term shows up as a wrong `vectorAddr` or `hwClear` in the strobe cycle itself.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam int NUM_SRC = 15;
  localparam int VEC_W   = 16;
  localparam int IDX_W   = $clog2(NUM_SRC);

  typedef struct packed {
    logic issue;
    logic issueHigh;
  } ctlStrobe_t;

  function automatic logic [VEC_W-1:0] vecOf(input int idx);
    case (idx)
      0:       return VEC_W'(16'h0003);
      1:       return VEC_W'(16'h004B);
      2:       return VEC_W'(16'h0053);
      3:       return VEC_W'(16'h000B);
      4:       return VEC_W'(16'h0033);
      5:       return VEC_W'(16'h005B);
      6:       return VEC_W'(16'h0013);
      7:       return VEC_W'(16'h0043);
      8:       return VEC_W'(16'h0063);
      9:       return VEC_W'(16'h001B);
      10:      return VEC_W'(16'h003B);
      11:      return VEC_W'(16'h006B);
      12:      return VEC_W'(16'h0023);
      13:      return VEC_W'(16'h002B);
      default: return VEC_W'(16'h0073);
    endcase
  endfunction

  // sources whose flag is dropped by hardware on entry; ext0/ext1 depend on trigger mode
  function automatic logic [NUM_SRC-1:0] autoClrMask(input logic [1:0] edgeMode);
    logic [NUM_SRC-1:0] m;
    m = '0;
    m[2] = 1'b1; m[3] = 1'b1; m[5] = 1'b1; m[8] = 1'b1;
    m[9] = 1'b1; m[11] = 1'b1; m[14] = 1'b1;
    m[0] = edgeMode[0];
    m[6] = edgeMode[1];
    return m;
  endfunction
endpackage

// File: rtl/irq_vector_dp.sv
module irq_vector_dp
  import irq_vector_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqFlags,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcPrio,
  input  logic               globalEnable,
  input  logic [1:0]         edgeTrig,
  input  ctlStrobe_t         ctl,
  output logic               anyHigh,
  output logic               anyReq,
  output logic [VEC_W-1:0]   vectorAddr,
  output logic [NUM_SRC-1:0] hwClear
);
  logic [NUM_SRC-1:0] sampleQ;
  logic [NUM_SRC-1:0] eligible, highVec, lowVec;
  logic [VEC_W-1:0]   vecTable [NUM_SRC];
  logic [IDX_W-1:0]   highIdx, lowIdx, winIdx;
  logic               highHit, lowHit;

  always_ff @(posedge clk) begin
    if (!rstN) sampleQ <= '0;
    else       sampleQ <= reqFlags;
  end

  assign eligible = sampleQ & srcEnable & {NUM_SRC{globalEnable}};
  assign highVec  = eligible & srcPrio;
  assign lowVec   = eligible & ~srcPrio;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
    assign vecTable[g] = vecOf(g);
  end

  always_comb begin
    highIdx = '0; highHit = 1'b0;
    lowIdx  = '0; lowHit  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (highVec[i]) begin highHit = 1'b1; highIdx = IDX_W'(i); end
      if (lowVec[i])  begin lowHit  = 1'b1; lowIdx  = IDX_W'(i); end
    end
  end

  assign anyHigh = highHit;
  assign anyReq  = highHit | lowHit;
  assign winIdx  = highHit ? highIdx : lowIdx;

  always_comb begin
    vectorAddr = '0;
    hwClear    = '0;
    if (ctl.issue) begin
      vectorAddr = vecTable[winIdx];
      hwClear    = (NUM_SRC'(1) << winIdx) & autoClrMask(edgeTrig);
    end
  end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_vector_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyHigh,
  input  logic       anyReq,
  input  logic       lastCycle,
  input  logic       guardInstr,
  input  logic       retiPulse,
  output ctlStrobe_t ctl,
  output logic [1:0] inService
);
  logic levelBlocked;

  // bit 1 blocks everything; bit 0 blocks only low-level winners
  assign levelBlocked = inService[1] | (!anyHigh & inService[0]);

  always_comb begin
    ctl.issue     = anyReq & lastCycle & !guardInstr & !levelBlocked;
    ctl.issueHigh = anyHigh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inService <= '0;
    end else begin
      logic [1:0] nxt;
      nxt = inService;
      if (retiPulse) begin
        if (nxt[1]) nxt[1] = 1'b0;
        else        nxt[0] = 1'b0;
      end
      if (ctl.issue) nxt[ctl.issueHigh] = 1'b1;
      inService <= nxt;
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vector_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqFlags,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] srcPrio,
  input  logic               globalEnable,
  input  logic [1:0]         edgeTrig,
  input  logic               lastCycle,
  input  logic               guardInstr,
  input  logic               retiPulse,
  output logic               callReq,
  output logic [VEC_W-1:0]   vectorAddr,
  output logic [NUM_SRC-1:0] hwClear
);
  ctlStrobe_t ctl;
  logic       anyHigh, anyReq;
  logic [1:0] inService;

  irq_vector_dp u_dp (
    .clk(clk), .rstN(rstN), .reqFlags(reqFlags), .srcEnable(srcEnable),
    .srcPrio(srcPrio), .globalEnable(globalEnable), .edgeTrig(edgeTrig),
    .ctl(ctl), .anyHigh(anyHigh), .anyReq(anyReq),
    .vectorAddr(vectorAddr), .hwClear(hwClear)
  );

  irq_vector_ctl u_ctl (
    .clk(clk), .rstN(rstN), .anyHigh(anyHigh), .anyReq(anyReq),
    .lastCycle(lastCycle), .guardInstr(guardInstr), .retiPulse(retiPulse),
    .ctl(ctl), .inService(inService)
  );

  assign callReq = ctl.issue;
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk
  import irq_vector_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] reqFlags,
  input logic               globalEnable,
  input logic               lastCycle,
  input logic               guardInstr,
  input logic               callReq,
  input logic [VEC_W-1:0]   vectorAddr,
  input logic [NUM_SRC-1:0] hwClear,
  input logic [1:0]         inService
);
  // R1
  sampled_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> $past(reqFlags) != '0);
  // R2
  level_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> !inService[1]);
  // R3
  final_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> lastCycle);
  // R4
  guard_instr_chk: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> !guardInstr);
  // R10
  global_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> globalEnable);
  // R11
  vector_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> vectorAddr != '0);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !callReq |-> (vectorAddr == '0 && hwClear == '0));
  // R9
  clear_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hwClear));
endmodule

bind irq_vector_unit irq_vector_chk u_chk (
  .clk(clk), .rstN(rstN), .reqFlags(reqFlags), .globalEnable(globalEnable),
  .lastCycle(lastCycle), .guardInstr(guardInstr), .callReq(callReq),
  .vectorAddr(vectorAddr), .hwClear(hwClear), .inService(inService)
);

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic [14:0] reqFlags, srcEnable, srcPrio, hwClear;
  logic        globalEnable, lastCycle, guardInstr, retiPulse, callReq;
  logic [1:0]  edgeTrig;
  logic [15:0] vectorAddr;
  int          errors = 0, checks = 0;

  logic [15:0] expVec [15] = '{16'h0003, 16'h004B, 16'h0053, 16'h000B, 16'h0033,
                               16'h005B, 16'h0013, 16'h0043, 16'h0063, 16'h001B,
                               16'h003B, 16'h006B, 16'h0023, 16'h002B, 16'h0073};
  localparam logic [14:0] CLR_SET = 15'b100_1011_0110_1101;

  always #5 clk = ~clk;

  irq_vector_unit dut (
    .clk(clk), .rstN(rstN), .reqFlags(reqFlags), .srcEnable(srcEnable),
    .srcPrio(srcPrio), .globalEnable(globalEnable), .edgeTrig(edgeTrig),
    .lastCycle(lastCycle), .guardInstr(guardInstr), .retiPulse(retiPulse),
    .callReq(callReq), .vectorAddr(vectorAddr), .hwClear(hwClear)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nextCycle();
    @(negedge clk); #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqFlags = '0; retiPulse = 1'b0; srcEnable = '1; srcPrio = '0;
    globalEnable = 1'b1; edgeTrig = 2'b11; lastCycle = 1'b1; guardInstr = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testResetState();
    doReset(); #1;
    chk("R12 callReq after reset", 32'(callReq), 0);
    chk("R12 vector after reset", 32'(vectorAddr), 0);
    chk("R12 hwClear after reset", 32'(hwClear), 0);
  endtask

  task automatic testEachSource();
    for (int i = 0; i < 15; i++) begin
      doReset();
      reqFlags = 15'(1) << i; #1;
      chk("R1 no call before capture edge", 32'(callReq), 0);
      nextCycle();
      chk("R11 call strobe", 32'(callReq), 1);
      chk("R8 vector", 32'(vectorAddr), 32'(expVec[i]));
      chk("R9 hw clear", 32'(hwClear), 32'(CLR_SET & (15'(1) << i)));
      nextCycle();
      chk("R11 strobe one cycle / R2 same level", 32'(callReq), 0);
      reqFlags = '0;
    end
    doReset();
    edgeTrig = 2'b00; reqFlags = 15'(1) << 6;
    nextCycle();
    chk("R9 level ext1 not cleared", 32'(hwClear), 0);
    chk("R8 ext1 vector", 32'(vectorAddr), 32'h13);
  endtask

  task automatic testOrder();
    doReset();
    reqFlags = (15'(1) << 6) | (15'(1) << 9) | (15'(1) << 14);
    nextCycle();
    chk("R6 ext1 over timer1 and ext6", 32'(vectorAddr), 32'h13);
    doReset();
    reqFlags = 15'b110;
    nextCycle();
    chk("R6 index 1 over index 2", 32'(vectorAddr), 32'h4B);
    doReset();
    srcPrio = 15'(1) << 14; reqFlags = 15'(1) | (15'(1) << 14);
    nextCycle();
    chk("R7 high level beats index 0", 32'(vectorAddr), 32'h73);
  endtask

  task automatic testNesting();
    doReset();
    srcPrio = 15'(1) << 8; reqFlags = 15'(1) << 3;
    nextCycle();
    chk("R7 low call timer0", 32'(vectorAddr), 32'h0B);
    reqFlags = 15'(1) << 8;
    nextCycle();
    chk("R7 high preempts low routine", 32'(vectorAddr), 32'h63);
    reqFlags = 15'(1) << 14;
    nextCycle();
    chk("R2 low blocked under high", 32'(callReq), 0);
    retiPulse = 1'b1;
    nextCycle();
    retiPulse = 1'b0;
    chk("R12 low still blocked after one return", 32'(callReq), 0);
    reqFlags = 15'(1) << 8;
    nextCycle();
    chk("R12 high free after return", 32'(vectorAddr), 32'h63);
    reqFlags = '0;
  endtask

  task automatic testBlocking();
    doReset();
    lastCycle = 1'b0; reqFlags = 15'(1) << 3;
    nextCycle();
    chk("R3 blocked mid instruction", 32'(callReq), 0);
    lastCycle = 1'b1; #1;
    chk("R3 call on final cycle", 32'(callReq), 1);
    doReset();
    guardInstr = 1'b1; reqFlags = 15'(1) << 3;
    nextCycle();
    chk("R4 blocked by guarded instruction", 32'(callReq), 0);
    nextCycle();
    chk("R4 still blocked", 32'(callReq), 0);
    guardInstr = 1'b0; #1;
    chk("R4 call after guard ends", 32'(callReq), 1);
  endtask

  task automatic testNoMemory();
    doReset();
    edgeTrig = 2'b00; lastCycle = 1'b0; reqFlags = 15'(1);
    nextCycle(); nextCycle();
    chk("R3 level request held off", 32'(callReq), 0);
    reqFlags = '0;
    nextCycle();
    lastCycle = 1'b1; #1;
    chk("R5 dropped request not served", 32'(callReq), 0);
    nextCycle();
    chk("R5 dropped request still not served", 32'(callReq), 0);
  endtask

  task automatic testMasking();
    doReset();
    globalEnable = 1'b0; reqFlags = 15'(1);
    nextCycle();
    chk("R10 global disable", 32'(callReq), 0);
    globalEnable = 1'b1; srcEnable = ~15'(1); reqFlags = 15'(1) | (15'(1) << 14);
    nextCycle();
    chk("R10 masked source skipped", 32'(vectorAddr), 32'h73);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    testResetState();
    testEachSource();
    testOrder();
    testNesting();
    testBlocking();
    testNoMemory();
    testMasking();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule